// File: doc/BRIEF.md
# Programmable Stop-Clock Release Delay

This block holds off the release of a processor stop-clock signal for a programmed time after the processor sleep signal goes inactive. Power sequencing logic upstream raises a stop-clock request. The block passes that request to its stop-clock output. Once sleep is inactive while the request stands, the block counts a programmed number of fixed-period ticks. When the count completes, the block lets stop-clock go inactive. A reasserted sleep or a withdrawn request abandons the count without a partial release.

The delay is set through an 8-bit configuration register. The low six bits give the tick count, and the upper two bits are reserved and read as zero. Ticks come from a prescaler that divides the system clock by `TICK_CLKS`. The default of 128 cycles gives roughly 3.87 microseconds per tick on a 33 MHz clock. With that tick, the reset setting of 13 gives about 50 microseconds and the top setting of 63 gives about 245 microseconds. Settings below two are not legal, and the block treats them as two.

Top module: `stpclk_release_delay`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x0D.
- R2: A write (`cfg_wr_en` high at a clock edge) stores `cfg_wr_data[5:0]` in bits 5:0 of the register. Bits 7:6 are ignored on write and always read as zero.
- R3: While `stop_req` is low, `stop_clk` is low in the same cycle.
- R4: Call a clock edge that samples `stop_req` high and `cpu_sleep` low, while the block is idle or holding, the start edge. With effective count N, `stop_clk` is high from the start edge until start edge + N*`TICK_CLKS`, and goes low at that edge.
- R5: Register values 0 and 1 give an effective count of 2. Values 2 to 63 are used as they are.
- R6: If `cpu_sleep` rises during a count, `stop_clk` stays high and the partial count is discarded. The next start edge times a full interval.
- R7: If `stop_req` falls during a count, `stop_clk` falls in the same cycle and the count is discarded. A later request times a full interval.
- R8: A register write made during a count leaves that interval's length unchanged and applies from the next start edge.
- R9: After release, `stop_clk` stays low while `stop_req` is high and `cpu_sleep` is low. If `cpu_sleep` rises, `stop_clk` is high after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write data |
| cfg_rd_data | output | 8 | Register read data, bits 7:6 zero |
| cpu_sleep | input | 1 | Processor sleep, high = asserted |
| stop_req | input | 1 | Stop-clock request, high = asserted |
| stop_clk | output | 1 | Stop-clock to processor, high = asserted |

## Verification
If the tick counter or prescaler holds a wrong value, the release edge of `stop_clk` shifts by at least one cycle. The bench measures that edge to the exact cycle for every register value, so the error shows on the first interval timed. A latched limit that fails to freeze, or a count that survives an abort, shows as an early release within the same interval. A broken release state shows one edge after `cpu_sleep` rises or within the cycles that follow a release.

// File: rtl/stpd_pkg.sv
package stpd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HOLD     = 2'd1,
        ST_COUNT    = 2'd2,
        ST_RELEASED = 2'd3
    } stpd_state_e;
endpackage

// File: rtl/stpd_cfg_reg.sv
module stpd_cfg_reg #(
    parameter int REG_W     = 8,
    parameter int FIELD_W   = 6,
    parameter int RESET_VAL = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [FIELD_W-1:0] field
);
    localparam int PAD_W = REG_W - FIELD_W;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
    } cfg_t;

    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) r_d.field = wr_data[FIELD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.field <= FIELD_W'(RESET_VAL);
        else        r_q <= r_d;
    end

    assign field   = r_q.field;
    assign rd_data = {{PAD_W{1'b0}}, r_q.field};

    // R2: a write lands in the field by the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[FIELD_W-1:0] == $past(wr_data[FIELD_W-1:0])));
endmodule

// File: rtl/stpd_tick_gen.sv
module stpd_tick_gen #(
    parameter int TICK_CLKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tg_t;

    tg_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        tick = 1'b0;
        if (!run) begin
            t_d.cnt = '0;
        end else if (t_q.cnt == CNT_W'(TICK_CLKS - 1)) begin
            tick    = 1'b1;
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    generate
        if (TICK_CLKS > 1) begin : g_spacing
            // R4: ticks are never back to back when the period exceeds one cycle
            a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/stpd_sequencer.sv
module stpd_sequencer
    import stpd_pkg::*;
#(
    parameter int FIELD_W   = 6,
    parameter int MIN_COUNT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] setting,
    input  logic               sleep,
    input  logic               req,
    input  logic               tick,
    output logic               run,
    output logic               stop_out
);
    typedef struct packed {
        stpd_state_e        st;
        logic [FIELD_W-1:0] cnt;
        logic [FIELD_W-1:0] limit;
    } seq_t;

    seq_t s_d, s_q;
    logic [FIELD_W-1:0] eff_limit;

    always_comb begin
        eff_limit = (setting < FIELD_W'(MIN_COUNT)) ? FIELD_W'(MIN_COUNT) : setting;
        s_d = s_q;
        if (!req) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE, ST_HOLD: begin
                    s_d.cnt = '0;
                    if (!sleep) begin
                        s_d.st    = ST_COUNT;
                        s_d.limit = eff_limit;
                    end else begin
                        s_d.st = ST_HOLD;
                    end
                end
                ST_COUNT: begin
                    if (sleep) begin
                        s_d.st  = ST_HOLD;
                        s_d.cnt = '0;
                    end else if (tick) begin
                        if (s_q.cnt == s_q.limit - 1'b1) begin
                            s_d.st  = ST_RELEASED;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RELEASED: begin
                    if (sleep) s_d.st = ST_HOLD;
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.cnt   <= '0;
            s_q.limit <= FIELD_W'(MIN_COUNT);
        end else begin
            s_q <= s_d;
        end
    end

    assign run      = (s_q.st == ST_COUNT);
    assign stop_out = req && (s_q.st != ST_RELEASED);

    // R6: sleep during a count returns to holding
    a_r6_sleep_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (req && s_q.st == ST_COUNT && sleep) |=> (s_q.st == ST_HOLD));
    // R8: the latched limit does not move inside an interval
    a_r8_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COUNT && $past(s_q.st == ST_COUNT)) |-> $stable(s_q.limit));
    // R5: counts never run below the legal minimum
    a_r5_min_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COUNT) |-> (s_q.limit >= FIELD_W'(MIN_COUNT)));
    // R4: release is entered only from a count on a tick
    a_r4_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RELEASED && $past(s_q.st != ST_RELEASED))
            |-> $past(tick && s_q.st == ST_COUNT));
endmodule

// File: rtl/stpclk_release_delay.sv
module stpclk_release_delay #(
    parameter int REG_W     = 8,
    parameter int FIELD_W   = 6,
    parameter int RESET_VAL = 13,
    parameter int MIN_COUNT = 2,
    parameter int TICK_CLKS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             cpu_sleep,
    input  logic             stop_req,
    output logic             stop_clk
);
    logic [FIELD_W-1:0] setting;
    logic               run;
    logic               tick;

    stpd_cfg_reg #(.REG_W(REG_W), .FIELD_W(FIELD_W), .RESET_VAL(RESET_VAL)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
        .rd_data(cfg_rd_data), .field(setting)
    );

    stpd_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    stpd_sequencer #(.FIELD_W(FIELD_W), .MIN_COUNT(MIN_COUNT)) u_seq (
        .clk(clk), .rst_n(rst_n), .setting(setting), .sleep(cpu_sleep),
        .req(stop_req), .tick(tick), .run(run), .stop_out(stop_clk)
    );

    // R3: no stop-clock without a request
    a_r3_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |-> !stop_clk);
endmodule

// File: tb/sim_stpclk_release_delay.sv
module sim_stpclk_release_delay;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       cpu_sleep = 1'b1;
    logic       stop_req = 1'b0;
    logic       stop_clk;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    stpclk_release_delay #(.TICK_CLKS(P)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .cpu_sleep(cpu_sleep), .stop_req(stop_req),
        .stop_clk(stop_clk)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic hold_up();
        @(negedge clk);
        stop_req = 1'b1; cpu_sleep = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // drop sleep, count negedges until stop_clk falls
    task automatic measure(output int k);
        cpu_sleep = 1'b0;
        k = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            k++;
            if (!stop_clk) break;
        end
    endtask

    function automatic int eff(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R1: reset value
        check("R1 reset read", int'(cfg_rd_data), 8'h0D);
        check("R3 idle stop_clk", int'(stop_clk), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: default setting times 13 ticks
        hold_up();
        check("R3 stop_clk follows request", int'(stop_clk), 1);
        measure(k);
        check("R4 default interval", k, 13 * P + 1);

        // R2: reserved bits ignored
        wr(8'hFF);
        check("R2 reserved bits zero", int'(cfg_rd_data), 8'h3F);
        wr(8'hC5);
        check("R2 field only", int'(cfg_rd_data), 8'h05);

        // R4, R5: exhaustive sweep of the field
        for (int v = 0; v < 64; v++) begin
            wr(8'(v));
            check("R2 readback", int'(cfg_rd_data), v);
            hold_up();
            measure(k);
            if (v < 2) check("R5 minimum count", k, eff(v) * P + 1);
            else       check("R4 interval length", k, eff(v) * P + 1);
        end

        // R9: stays released, sleep re-asserts stop-clock
        repeat (10) @(negedge clk);
        check("R9 stays released", int'(stop_clk), 0);
        cpu_sleep = 1'b1;
        @(negedge clk);
        check("R9 sleep reasserts", int'(stop_clk), 1);

        // R6: sleep reasserted mid-count
        wr(8'd10);
        hold_up();
        cpu_sleep = 1'b0;
        repeat (25) @(negedge clk);
        cpu_sleep = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 held after abort", int'(stop_clk), 1);
        measure(k);
        check("R6 full interval after abort", k, 10 * P + 1);

        // R7: request withdrawn mid-count
        hold_up();
        cpu_sleep = 1'b0;
        repeat (20) @(negedge clk);
        stop_req = 1'b0;
        #1;
        check("R7 immediate drop", int'(stop_clk), 0);
        @(negedge clk);
        stop_req = 1'b1;
        #1;
        check("R3 request back", int'(stop_clk), 1);
        measure(k);
        check("R7 full interval after withdraw", k, 10 * P + 1);

        // R8: write during a count
        wr(8'd5);
        hold_up();
        cpu_sleep = 1'b0;
        k = 0;
        for (int i = 0; i < 400; i++) begin
            if (k == 3) begin
                cfg_wr_en = 1'b1; cfg_wr_data = 8'd40;
            end else begin
                cfg_wr_en = 1'b0;
            end
            @(negedge clk);
            k++;
            if (!stop_clk) break;
        end
        cfg_wr_en = 1'b0;
        check("R8 current interval unchanged", k, 5 * P + 1);
        hold_up();
        measure(k);
        check("R8 next interval uses new value", k, 40 * P + 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule